// File: doc/BRIEF.md
# Asymmetric Three-Slot Decode Steering Unit

This unit sits between a sixteen-entry instruction buffer and a six-entry micro-op queue. Each buffered instruction has already been pre-decoded into a tag, a micro-op count between one and four, and a branch flag. Every cycle the unit forms a decode group of up to three consecutive instructions and places them on three unequal slots. Slot 0 accepts an instruction of any size. Slots 1 and 2 accept only single-micro-op instructions. The micro-ops of the group are appended to the internal queue, and up to three of them leave the queue per cycle toward dispatch.

Instructions are taken strictly in program order. A multi-micro-op instruction that lands on slot 1 or 2 ends the group for that cycle. It then moves one slot closer to slot 0 each time the head moves, until it reaches slot 0 and is decoded there. A branch also ends the group. A group is written to the queue whole or not at all. The buffer is reloaded only once every one of its sixteen entries has been consumed. A refill request marks the single cycle in which it is empty.

Top module: `dsteer_top`

## Requirements
- R1: While reset is held, `refill_req` is 1, `disp_vld` is 0 and `dec_slots` is 0.
- R2: When room allows, slot 0 always decodes the oldest buffered instruction, whatever its count (1 to 4; each count field holds the count minus one). Its micro-ops enter the queue with indices 0 up to count-1, in that order.
- R3: Slot s (1 or 2) decodes an instruction only if slot s-1 decoded the instruction just before it and its own count is 1. A multi-micro-op instruction seen by slot 1 or 2 ends the group, and nothing after it is decoded in that cycle.
- R4: At most one branch is decoded per cycle. No slot after a decoded branch is used in the same cycle.
- R5: A group is decoded only if its total micro-op count fits in the queue's free space at the start of the cycle (6 minus occupancy). Otherwise `dec_slots` and `dec_uops` are 0 and the head does not move.
- R6: Micro-ops leave the queue in program order: instruction order first, then ascending index within an instruction.
- R7: `disp_vld[i]` is 1 exactly when the queue holds more than i micro-ops. When `disp_rdy` is 1 at a clock edge, min(3, occupancy) micro-ops are removed at that edge.
- R8: `refill_req` is 1 exactly in the cycles when every buffer entry has been consumed. At the edge that ends such a cycle, the buffer loads `fill_um1`, `fill_br` and `fill_tag`. Entry j is taken from bits [2j+1:2j], bit j and bits [8j+7:8j] respectively. No slot decodes while `refill_req` is 1.
- R9: `dec_uops` equals the number of micro-ops written to the queue in the current cycle. Bit s of `dec_slots` is 1 when slot s decodes an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_um1 | input | 32 | Per-entry micro-op count minus one for the new buffer contents |
| fill_br | input | 16 | Per-entry branch flag for the new buffer contents |
| fill_tag | input | 128 | Per-entry 8-bit instruction tag for the new buffer contents |
| refill_req | output | 1 | Buffer is empty; fill inputs are loaded at the next edge |
| dec_slots | output | 3 | Slots that decode an instruction this cycle |
| dec_uops | output | 3 | Micro-ops written to the queue this cycle |
| disp_rdy | input | 1 | Dispatch takes up to three micro-ops at the next edge |
| disp_vld | output | 3 | Valid flags of the three oldest queued micro-ops |
| disp_tag | output | 24 | Tags of the three oldest micro-ops, lane i in bits [8i+7:8i] |
| disp_idx | output | 6 | Micro-op indices of the three oldest micro-ops, lane i in bits [2i+1:2i] |

## Verification
The bench feeds buffers made only of four-micro-op instructions, which keep the queue near full and force the shift toward slot 0 on every group. A unit that let such an instruction decode on slot 1 would emit too many micro-ops. A unit that skipped ahead of it would break queue order. Buffers made only of branches check the one-branch limit: a unit that ignored the branch stop would report more than one active slot. Periods with dispatch held off fill the queue, and a partial write at that point would surface as a group that exceeds the free space or as lost micro-ops in the scoreboard. Each refill cycle is checked so that a missed or extra empty cycle, or a decode during reload, shows up as a shifted head and wrong tags.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;
    parameter int TAG_W    = 8;
    parameter int MAX_UOPS = 4;
    localparam int UCNT_W  = $clog2(MAX_UOPS);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [UCNT_W-1:0] um1;
        logic              br;
    } ins_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [UCNT_W-1:0] idx;
    } uop_t;
endpackage

// File: rtl/dsteer_pick.sv
module dsteer_pick
    import dsteer_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int QDEPTH = 6,
    localparam int NW    = MAX_UOPS + NSLOT - 1,
    localparam int UW    = $clog2(NW + 1),
    localparam int FW    = $clog2(QDEPTH + 1)
) (
    input  ins_t             win [NSLOT],
    input  logic [NSLOT-1:0] win_vld,
    input  logic [FW-1:0]    free,
    output logic [NSLOT-1:0] take,
    output logic [UW-1:0]    nuop
);
    logic [NSLOT-1:0] cand;
    logic [UW-1:0]    sum;
    logic             open;

    always_comb begin
        cand = '0;
        sum  = '0;
        open = 1'b1;
        for (int s = 0; s < NSLOT; s++) begin
            if (open && win_vld[s] && (s == 0 || win[s].um1 == '0)) begin
                cand[s] = 1'b1;
                sum     = sum + UW'(win[s].um1) + UW'(1);
                open    = !win[s].br;
            end else begin
                open = 1'b0;
            end
        end
        if (int'(sum) <= int'(free)) begin
            take = cand;
            nuop = sum;
        end else begin
            take = '0;
            nuop = '0;
        end
    end
endmodule

// File: rtl/dsteer_uq.sv
module dsteer_uq
    import dsteer_pkg::*;
#(
    parameter int QDEPTH = 6,
    parameter int NW     = 6,
    parameter int NR     = 3,
    localparam int PW    = $clog2(QDEPTH),
    localparam int FW    = $clog2(QDEPTH + 1),
    localparam int UW    = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [UW-1:0] wr_n,
    input  uop_t          wr [NW],
    input  logic          rd_rdy,
    output logic [FW-1:0] occ,
    output logic [NR-1:0] rd_vld,
    output uop_t          rd [NR]
);
    typedef struct packed {
        uop_t [QDEPTH-1:0] mem;
        logic [PW-1:0]     hd;
        logic [FW-1:0]     occ;
    } uq_st_t;

    uq_st_t st_d, st_q;
    int     npop;

    always_comb begin
        st_d = st_q;
        npop = 0;
        if (rd_rdy) npop = (int'(st_q.occ) >= NR) ? NR : int'(st_q.occ);
        for (int k = 0; k < NW; k++) begin
            if (k < int'(wr_n))
                st_d.mem[PW'((int'(st_q.hd) + int'(st_q.occ) + k) % QDEPTH)] = wr[k];
        end
        st_d.hd  = PW'((int'(st_q.hd) + npop) % QDEPTH);
        st_d.occ = FW'(int'(st_q.occ) + int'(wr_n) - npop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NR; i++) begin : g_rd
        assign rd[i]     = st_q.mem[PW'((int'(st_q.hd) + i) % QDEPTH)];
        assign rd_vld[i] = int'(st_q.occ) > i;
    end
    assign occ = st_q.occ;

    // R5: the queue never holds more than its depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.occ) <= QDEPTH);

    // R7: a ready dispatch with no new writes always shrinks a non-empty queue
    a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rdy && wr_n == '0 && st_q.occ != '0) |=> (st_q.occ < $past(st_q.occ)));
endmodule

// File: rtl/dsteer_top.sv
module dsteer_top
    import dsteer_pkg::*;
#(
    parameter int BUF_N  = 16,
    parameter int NSLOT  = 3,
    parameter int QDEPTH = 6,
    parameter int NDISP  = 3,
    localparam int NW    = MAX_UOPS + NSLOT - 1,
    localparam int UW    = $clog2(NW + 1),
    localparam int FW    = $clog2(QDEPTH + 1),
    localparam int HW    = $clog2(BUF_N + 1),
    localparam int IW    = $clog2(BUF_N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BUF_N*UCNT_W-1:0]   fill_um1,
    input  logic [BUF_N-1:0]          fill_br,
    input  logic [BUF_N*TAG_W-1:0]    fill_tag,
    output logic                      refill_req,
    output logic [NSLOT-1:0]          dec_slots,
    output logic [UW-1:0]             dec_uops,
    input  logic                      disp_rdy,
    output logic [NDISP-1:0]          disp_vld,
    output logic [NDISP*TAG_W-1:0]    disp_tag,
    output logic [NDISP*UCNT_W-1:0]   disp_idx
);
    typedef struct packed {
        ins_t [BUF_N-1:0] ibuf;
        logic [HW-1:0]    hd;
    } top_st_t;

    top_st_t          st_d, st_q;
    ins_t             win [NSLOT];
    logic [NSLOT-1:0] win_vld;
    logic [NSLOT-1:0] take;
    logic [UW-1:0]    nuop;
    logic [FW-1:0]    occ;
    uop_t             wr [NW];
    uop_t             rd [NDISP];
    int               ntake;
    int               lane;

    assign refill_req = (st_q.hd == HW'(BUF_N));

    // window: the slot s sees the instruction s places behind the head
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            win_vld[s] = 1'b0;
            win[s]     = '0;
            if (int'(st_q.hd) + s < BUF_N) begin
                win_vld[s] = 1'b1;
                win[s]     = st_q.ibuf[IW'(int'(st_q.hd) + s)];
            end
        end
    end

    dsteer_pick #(.NSLOT(NSLOT), .QDEPTH(QDEPTH)) u_pick (
        .win     (win),
        .win_vld (win_vld),
        .free    (FW'(QDEPTH) - occ),
        .take    (take),
        .nuop    (nuop)
    );

    always_comb begin
        st_d  = st_q;
        ntake = 0;
        lane  = 0;
        for (int k = 0; k < NW; k++) wr[k] = '0;
        if (refill_req) begin
            for (int j = 0; j < BUF_N; j++) begin
                st_d.ibuf[j].tag = fill_tag[j*TAG_W +: TAG_W];
                st_d.ibuf[j].um1 = fill_um1[j*UCNT_W +: UCNT_W];
                st_d.ibuf[j].br  = fill_br[j];
            end
            st_d.hd = '0;
        end else begin
            for (int s = 0; s < NSLOT; s++) begin
                if (take[s]) ntake++;
                for (int u = 0; u < MAX_UOPS; u++) begin
                    if (take[s] && u <= int'(win[s].um1) && lane < NW) begin
                        wr[lane].tag = win[s].tag;
                        wr[lane].idx = UCNT_W'(u);
                        lane++;
                    end
                end
            end
            st_d.hd = st_q.hd + HW'(ntake);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ibuf <= '0;
            st_q.hd   <= HW'(BUF_N);
        end else begin
            st_q <= st_d;
        end
    end

    dsteer_uq #(.QDEPTH(QDEPTH), .NW(NW), .NR(NDISP)) u_uq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n   (nuop),
        .wr     (wr),
        .rd_rdy (disp_rdy),
        .occ    (occ),
        .rd_vld (disp_vld),
        .rd     (rd)
    );

    for (genvar i = 0; i < NDISP; i++) begin : g_disp
        assign disp_tag[i*TAG_W +: TAG_W]   = rd[i].tag;
        assign disp_idx[i*UCNT_W +: UCNT_W] = rd[i].idx;
    end

    assign dec_slots = take;
    assign dec_uops  = nuop;

    // R8: no decode while the buffer is being reloaded
    a_r8_idle_on_refill: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> (dec_slots == '0));

    // R8: the empty cycle lasts exactly one cycle
    a_r8_refill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |=> !refill_req);

    // R5: a decoded group always fits the space left in the queue
    a_r5_group_fits: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dec_uops) <= QDEPTH - int'(occ));

    for (genvar g = 1; g < NSLOT; g++) begin : g_chk
        // R3: a slot is used only when the slot before it is used
        a_r3_in_order: assert property (@(posedge clk) disable iff (!rst_n)
            dec_slots[g] |-> dec_slots[g-1]);
        // R4: nothing follows a branch in the same cycle
        a_r4_one_branch: assert property (@(posedge clk) disable iff (!rst_n)
            dec_slots[g] |-> !win[g-1].br);
    end
endmodule

// File: tb/dsteer_top_tb.sv
`timescale 1ns/1ps
module dsteer_top_tb;
    localparam int BUF_N = 16;
    localparam int QD    = 6;
    localparam int NCYC  = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fill_um1 = '0;
    logic [15:0] fill_br = '0;
    logic [127:0] fill_tag = '0;
    logic        refill_req;
    logic [2:0]  dec_slots;
    logic [2:0]  dec_uops;
    logic        disp_rdy = 1'b0;
    logic [2:0]  disp_vld;
    logic [23:0] disp_tag;
    logic [5:0]  disp_idx;

    always #2 clk = ~clk;

    dsteer_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .fill_um1(fill_um1), .fill_br(fill_br), .fill_tag(fill_tag),
        .refill_req(refill_req), .dec_slots(dec_slots), .dec_uops(dec_uops),
        .disp_rdy(disp_rdy), .disp_vld(disp_vld),
        .disp_tag(disp_tag), .disp_idx(disp_idx)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [9:0] expq [$];

    int cur_um1 [BUF_N];
    bit cur_br  [BUF_N];
    int nxt_um1 [BUF_N];
    bit nxt_br  [BUF_N];
    int mhead = BUF_N;
    int occ = 0;
    int kbuf = 0;
    bit prev_refill = 1'b0;
    int prev_ntake = 0, prev_uops = 0, prev_pops = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // scoreboard driver: present buffer k and push its micro-ops in program order
    task automatic drive_buf(input int k);
        for (int j = 0; j < BUF_N; j++) begin
            int h, um, tg;
            bit b;
            h = k * 31 + j * 17 + j * j;
            case (k % 4)
                0: begin um = (h % 3 == 0) ? (h % 4) : 0; b = ((h / 4) % 5 == 0); end
                1: begin um = 3; b = (j % 5 == 0); end
                2: begin um = 0; b = 1'b1; end
                default: begin um = 0; b = 1'b0; end
            endcase
            tg = (k * 16 + j) % 256;
            fill_um1[j*2 +: 2] = 2'(um);
            fill_br[j]         = b;
            fill_tag[j*8 +: 8] = 8'(tg);
            nxt_um1[j] = um;
            nxt_br[j]  = b;
            for (int u = 0; u <= um; u++) expq.push_back({8'(tg), 2'(u)});
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "refill_req in reset", int'(refill_req), 1);
        chk("R1", "disp_vld in reset", int'(disp_vld), 0);
        chk("R1", "dec_slots in reset", int'(dec_slots), 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            int free, sum, npop, jj;
            bit open;
            logic [2:0] mask;
            string reason;
            // model update from the edge just passed
            if (prev_refill) begin
                for (int j = 0; j < BUF_N; j++) begin
                    cur_um1[j] = nxt_um1[j];
                    cur_br[j]  = nxt_br[j];
                end
                mhead = 0;
            end else begin
                mhead += prev_ntake;
            end
            occ += prev_uops - prev_pops;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            disp_rdy = (cyc % 97 < 25) ? 1'b0 : (lfsr[0] | lfsr[1]);

            chk("R8", "refill_req", int'(refill_req), int'(mhead == BUF_N));

            // expected group
            free = QD - occ; sum = 0; mask = '0; open = 1'b1; reason = "R2";
            for (int s = 0; s < 3; s++) begin
                jj = mhead + s;
                if (!open || jj >= BUF_N) break;
                if (s > 0 && cur_um1[jj] != 0) begin reason = "R3"; break; end
                mask[s] = 1'b1;
                sum += cur_um1[jj] + 1;
                if (cur_br[jj]) begin
                    open = 1'b0;
                    if (s < 2 && jj + 1 < BUF_N) reason = "R4";
                end
            end
            if (sum > free) begin mask = '0; sum = 0; reason = "R5"; end
            chk(reason, "dec_slots", int'(dec_slots), int'(mask));
            chk("R9", "dec_uops", int'(dec_uops), sum);

            // R7: valid lanes follow occupancy
            chk("R7", "disp_vld", int'(disp_vld),
                (occ >= 3) ? 7 : (occ == 2) ? 3 : (occ == 1) ? 1 : 0);

            // scoreboard monitor: compare every micro-op that leaves this cycle
            npop = disp_rdy ? ((occ >= 3) ? 3 : occ) : 0;
            for (int i = 0; i < npop; i++) begin
                if (expq.size() == 0) begin
                    chk("R6", "unexpected micro-op", 1, 0);
                end else begin
                    logic [9:0] e;
                    e = expq.pop_front();
                    chk("R6", "dispatched tag", int'(disp_tag[i*8 +: 8]), int'(e[9:2]));
                    chk("R2", "dispatched index", int'(disp_idx[i*2 +: 2]), int'(e[1:0]));
                end
            end

            prev_refill = (mhead == BUF_N);
            prev_ntake  = int'(mask[0]) + int'(mask[1]) + int'(mask[2]);
            prev_uops   = sum;
            prev_pops   = npop;
            if (mhead == BUF_N) begin
                drive_buf(kbuf);
                kbuf++;
            end
            @(negedge clk);
        end
        chk("R8", "buffers refilled", int'(kbuf >= 20), 1);
        summary();
        $finish;
    end
endmodule